// File: doc/BRIEF.md
# I2C Controller Register Bank: Status, Interrupt and Soft Reset

This block is the byte-wide register bank that sits beside an I2C master engine. A host reaches it through a plain byte port over an 18-byte window. Writes take effect at a clock edge. Reads are combinational from the address. Each register has its own treatment of a written byte. Some bits are stored. Some are cleared when written as 1. Some are read-only live values. The rest are ignored.

The transfer engine has two inputs for pulsing status bits in: a four-bit event vector and a four-bit slave-event vector. It also has two live level inputs, bus busy and transfer busy. The bank combines the event vector with the interrupt mask and the interrupt-enable bit. From these it drives a single level-high interrupt line. Software drops that line by writing the status register.

A two-state sequencer handles the soft reset. In ST_RUN the host port is open. A write of bit0 to the extended control register takes the transition SRST_REQ into ST_SRST. ST_SRST lasts one cycle. During it the host port is closed, and the bank reloads its reset values at the end of that cycle. The transition SRST_DONE then returns the sequencer to ST_RUN.

Top module: `i2c_stat_regs`

## Requirements
- R1: After hard reset: offset 9 reads 0x40 with the bus free; offset 16 reads 0x0F; every other offset reads 0; irq is low; flush_pulse is low.
- R2: Offset 7 (mode control) stores only the bits in mask 0x3D, and its bit2 is the interrupt enable. Writing it with bit6 set makes flush_pulse high for exactly the cycle after the write edge. Bit6 always reads back as 0.
- R3: The following offsets store the full written byte: 4 and 5 (master address), 10 and 11 (slave address), 12 (clock divider) and 13 (interrupt mask). Offset 14 (transfer count) stores the written byte ANDed with 0x77. Offset 16 (direct control) stores the written byte ANDed with 0x0F.
- R4: The status register is at offset 8. Bit0 is xfer_busy, live. Bit1 is interrupt-active. Bit2 is error; it is set by ev_set[1] and is not writable. Bit3 is slave-pending; it is set by ev_set[2]. A write clears the written bits within mask 0x0A and leaves every other bit as it was.
- R5: The extended status register is at offset 9. Bits 6:4 read as 5 while bus_busy is high and as 4 while it is low. Bits 3:0 are set by the matching ev_set bits. Written bits within mask 0x8F are cleared.
- R6: Interrupt mask bit k selects ev_set[k]. The four events are: bit0 transfer done, bit1 abort, bit2 slave, bit3 halt. If any pulsed event is selected and mode bit2 is 1, then irq and status bit1 are both 1 after that edge.
- R7: Writing 1 to status bit1 lowers irq at that edge only if mode bit2 is 1. If mode bit2 is 0, irq stays high while status bit1 is still cleared.
- R8: Offset 15 (extended control) bits 7:4 are set by slv_set[3:0]. Written bits within mask 0xF0 are cleared. Bits 3:0 read as 0.
- R9: Writing bit0 of offset 15 starts a soft reset. A host write in the next cycle is ignored. After that cycle's edge, every register holds its R1 value, except the four address registers, which keep their contents. irq is low.
- R10: Offsets 0-3, 6, 17 and 18-31 read as 0. Writes to them change nothing.
- R11: An event that sets a bit wins over a same-cycle host write that clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| host_addr | input | 5 | Byte offset for reads and writes |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data at host_addr |
| ev_set | input | 4 | Engine event pulses: done, abort, slave, halt |
| slv_set | input | 4 | Slave status set pulses into offset 15 bits 7:4 |
| bus_busy | input | 1 | Bus occupied, live |
| xfer_busy | input | 1 | Transfer in progress, live |
| irq | output | 1 | Level-high interrupt |
| flush_pulse | output | 1 | One-cycle data buffer flush command |

## Verification
Every stored effect of a write or an event pulse becomes visible one edge after it, because host_rdata is a combinational mux of the registers. Live status fields (bus state and transfer busy) need no edge. flush_pulse is high only in the cycle after the write edge. A soft reset completes one edge later than the write that requests it. The bench drives every stimulus just after a rising edge and reads just after the edge that is due to update the result. For the flush pulse and the soft reset it also checks the cycle before and the cycle after.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int AW = 5;
    localparam int DW = 8;

    localparam logic [AW-1:0] OFF_MADR_LO = 5'd4;
    localparam logic [AW-1:0] OFF_MADR_HI = 5'd5;
    localparam logic [AW-1:0] OFF_MODE    = 5'd7;
    localparam logic [AW-1:0] OFF_STS     = 5'd8;
    localparam logic [AW-1:0] OFF_EXT     = 5'd9;
    localparam logic [AW-1:0] OFF_SADR_LO = 5'd10;
    localparam logic [AW-1:0] OFF_SADR_HI = 5'd11;
    localparam logic [AW-1:0] OFF_CLKDIV  = 5'd12;
    localparam logic [AW-1:0] OFF_INTMSK  = 5'd13;
    localparam logic [AW-1:0] OFF_COUNT   = 5'd14;
    localparam logic [AW-1:0] OFF_XCTL    = 5'd15;
    localparam logic [AW-1:0] OFF_DIRECT  = 5'd16;

    localparam logic [DW-1:0] MODE_KEEP  = 8'h3D;
    localparam logic [DW-1:0] STS_CLR    = 8'h0A;
    localparam logic [DW-1:0] EXT_CLR    = 8'h8F;
    localparam logic [DW-1:0] COUNT_KEEP = 8'h77;
    localparam logic [DW-1:0] XCTL_CLR   = 8'hF0;
    localparam logic [DW-1:0] DIR_KEEP   = 8'h0F;
    localparam logic [DW-1:0] DIR_RST    = 8'h0F;

    localparam int MODE_IEN_BIT   = 2;
    localparam int MODE_FLUSH_BIT = 6;
    localparam int XCTL_SRST_BIT  = 0;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_SRST = 1'b1
    } seq_state_t;
endpackage

// File: rtl/i2cs_rst_seq.sv
module i2cs_rst_seq
    import i2cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    output logic bank_init,
    output logic host_open
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (srst_req) state_d = ST_SRST;
            ST_SRST: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        bank_init = 1'b0;
        host_open = 1'b0;
        unique case (state_q)
            ST_RUN:  host_open = 1'b1;
            ST_SRST: bank_init = 1'b1;
            default: host_open = 1'b1;
        endcase
    end

    // R9
    srst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRST) |=> (state_q == ST_RUN));
endmodule

// File: rtl/i2cs_field_reg.sv
module i2cs_field_reg #(
    parameter int            W         = 8,
    parameter logic [W-1:0]  KEEP_MASK = '0,
    parameter logic [W-1:0]  CLR_MASK  = '0,
    parameter logic [W-1:0]  RST_VAL   = '0,
    parameter bit            SURVIVE   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         wr,
    input  logic [W-1:0] wd,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    logic [W-1:0] after_wr;
    logic         do_init;

    assign do_init = init && !SURVIVE;

    always_comb begin
        after_wr = q;
        if (wr) after_wr = ((q & ~KEEP_MASK) & ~(wd & CLR_MASK)) | (wd & KEEP_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= RST_VAL;
        else if (do_init) q <= RST_VAL;
        else              q <= after_wr | set;
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_init && !wr && set == '0) |=> $stable(q));
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_init && set != '0) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/i2cs_irq_ctl.sv
module i2cs_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic hit,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    irq <= 1'b0;
        else if (init) irq <= 1'b0;
        else if (hit)  irq <= 1'b1;
        else if (clr)  irq <= 1'b0;
    end

    // R6
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));
    // R7
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr || init));
endmodule

// File: rtl/i2c_stat_regs.sv
module i2c_stat_regs
    import i2cs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [3:0]    ev_set,
    input  logic [3:0]    slv_set,
    input  logic          bus_busy,
    input  logic          xfer_busy,
    output logic          irq,
    output logic          flush_pulse
);
    localparam int NADR = 4;
    localparam logic [NADR*AW-1:0] ADR_OFFS = {OFF_SADR_HI, OFF_SADR_LO, OFF_MADR_HI, OFF_MADR_LO};

    logic bank_init, host_open, hw;
    logic [DW-1:0] mode_q, sts_q, ext_q, clk_q, msk_q, cnt_q, xctl_q, dir_q;
    logic [DW-1:0] adr_q [NADR];
    logic irq_hit, irq_clr;

    assign hw = host_wr && host_open;

    function automatic logic wr_at(input logic en, input logic [AW-1:0] a, input logic [AW-1:0] off);
        return en && (a == off);
    endfunction

    i2cs_rst_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .srst_req(wr_at(hw, host_addr, OFF_XCTL) && host_wdata[XCTL_SRST_BIT]),
        .bank_init(bank_init), .host_open(host_open)
    );

    assign irq_hit = |(ev_set & msk_q[3:0]) && mode_q[MODE_IEN_BIT];
    assign irq_clr = wr_at(hw, host_addr, OFF_STS) && host_wdata[1] && mode_q[MODE_IEN_BIT];

    i2cs_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .init(bank_init),
        .hit(irq_hit), .clr(irq_clr), .irq(irq)
    );

    i2cs_field_reg #(.KEEP_MASK(MODE_KEEP)) u_mode (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_MODE)),
        .wd(host_wdata), .set('0), .q(mode_q));

    i2cs_field_reg #(.CLR_MASK(STS_CLR)) u_sts (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_STS)),
        .wd(host_wdata), .set({4'b0, ev_set[2], ev_set[1], irq_hit, 1'b0}), .q(sts_q));

    i2cs_field_reg #(.CLR_MASK(EXT_CLR)) u_ext (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_EXT)),
        .wd(host_wdata), .set({4'b0, ev_set}), .q(ext_q));

    i2cs_field_reg #(.KEEP_MASK(8'hFF)) u_clk (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_CLKDIV)),
        .wd(host_wdata), .set('0), .q(clk_q));

    i2cs_field_reg #(.KEEP_MASK(8'hFF)) u_msk (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_INTMSK)),
        .wd(host_wdata), .set('0), .q(msk_q));

    i2cs_field_reg #(.KEEP_MASK(COUNT_KEEP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_COUNT)),
        .wd(host_wdata), .set('0), .q(cnt_q));

    i2cs_field_reg #(.CLR_MASK(XCTL_CLR)) u_xctl (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_XCTL)),
        .wd(host_wdata), .set({slv_set, 4'b0}), .q(xctl_q));

    i2cs_field_reg #(.KEEP_MASK(DIR_KEEP), .RST_VAL(DIR_RST)) u_dir (
        .clk(clk), .rst_n(rst_n), .init(bank_init), .wr(wr_at(hw, host_addr, OFF_DIRECT)),
        .wd(host_wdata), .set('0), .q(dir_q));

    for (genvar g = 0; g < NADR; g++) begin : g_adr
        i2cs_field_reg #(.KEEP_MASK(8'hFF), .SURVIVE(1'b1)) u_adr (
            .clk(clk), .rst_n(rst_n), .init(bank_init),
            .wr(wr_at(hw, host_addr, ADR_OFFS[g*AW +: AW])),
            .wd(host_wdata), .set('0), .q(adr_q[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flush_pulse <= 1'b0;
        else        flush_pulse <= wr_at(hw, host_addr, OFF_MODE) && host_wdata[MODE_FLUSH_BIT];
    end

    always_comb begin
        case (host_addr)
            OFF_MADR_LO: host_rdata = adr_q[0];
            OFF_MADR_HI: host_rdata = adr_q[1];
            OFF_SADR_LO: host_rdata = adr_q[2];
            OFF_SADR_HI: host_rdata = adr_q[3];
            OFF_MODE:    host_rdata = mode_q;
            OFF_STS:     host_rdata = {4'b0, sts_q[3:1], xfer_busy};
            OFF_EXT:     host_rdata = {ext_q[7], bus_busy ? 3'd5 : 3'd4, ext_q[3:0]};
            OFF_CLKDIV:  host_rdata = clk_q;
            OFF_INTMSK:  host_rdata = msk_q;
            OFF_COUNT:   host_rdata = cnt_q;
            OFF_XCTL:    host_rdata = {xctl_q[7:4], 4'b0};
            OFF_DIRECT:  host_rdata = dir_q;
            default:     host_rdata = '0;
        endcase
    end

    // R2
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> $past(host_wr && host_addr == OFF_MODE && host_wdata[MODE_FLUSH_BIT]));
    // R9
    srst_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_init |=> (mode_q == '0 && msk_q == '0 && !irq));
endmodule

// File: tb/i2c_stat_regs_bench.sv
module i2c_stat_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] host_addr = '0;
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic [3:0] ev_set = '0, slv_set = '0;
    logic bus_busy = 1'b0, xfer_busy = 1'b0;
    logic irq, flush_pulse;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_stat_regs u_i2c_stat_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_set(ev_set),
        .slv_set(slv_set), .bus_busy(bus_busy), .xfer_busy(xfer_busy),
        .irq(irq), .flush_pulse(flush_pulse));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1 host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        host_addr = a; #1 v = host_rdata;
    endtask

    task automatic pulse(input logic [3:0] e, input logic [3:0] s);
        ev_set = e; slv_set = s;
        @(posedge clk); #1 ev_set = '0; slv_set = '0;
    endtask

    function automatic logic [7:0] rst_val(input int a);
        if (a == 9)  return 8'h40;
        if (a == 16) return 8'h0F;
        return 8'h00;
    endfunction

    initial begin
        logic [7:0] v;
        logic [7:0] snap [32];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset values
        for (int a = 0; a < 32; a++) begin rd(a[4:0], v); chk("R1", v, rst_val(a)); end
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 flush", {7'b0, flush_pulse}, 8'h00);

        // R2 / R3 exhaustive byte sweeps of stored registers
        for (int d = 0; d < 256; d++) begin
            wr(5'd7, d[7:0]);
            chk("R2 flush", {7'b0, flush_pulse}, {7'b0, d[6]});
            rd(5'd7, v); chk("R2 mode", v, d[7:0] & 8'h3D);
            wr(5'd14, d[7:0]); rd(5'd14, v); chk("R3 count", v, d[7:0] & 8'h77);
            wr(5'd16, d[7:0]); rd(5'd16, v); chk("R3 direct", v, d[7:0] & 8'h0F);
            wr(5'd12, d[7:0]); rd(5'd12, v); chk("R3 clkdiv", v, d[7:0]);
            wr(5'd4, d[7:0]);  rd(5'd4, v);  chk("R3 madr", v, d[7:0]);
        end
        wr(5'd7, 8'h40); chk("R2 flush on", {7'b0, flush_pulse}, 8'h01);
        @(posedge clk); #1 chk("R2 flush off", {7'b0, flush_pulse}, 8'h00);

        // R6 interrupt sweep with enable on
        wr(5'd7, 8'h04);
        for (int m = 0; m < 16; m++) begin
            wr(5'd13, m[7:0]);
            for (int e = 1; e < 16; e++) begin
                logic exp_i;
                exp_i = |(e[3:0] & m[3:0]);
                pulse(e[3:0], 4'h0);
                chk("R6 irq", {7'b0, irq}, {7'b0, exp_i});
                rd(5'd8, v); chk("R6 sts irqa", {7'b0, v[1]}, {7'b0, exp_i});
                wr(5'd8, 8'h0A);
                chk("R7 cleared", {7'b0, irq}, 8'h00);
            end
        end
        // R6 enable off gates the line
        wr(5'd7, 8'h00); pulse(4'hF, 4'h0);
        chk("R6 gated", {7'b0, irq}, 8'h00);

        // R7 clear ignored for the line when enable is off
        wr(5'd7, 8'h04); wr(5'd13, 8'h01); pulse(4'h1, 4'h0);
        wr(5'd7, 8'h00); wr(5'd8, 8'h02);
        chk("R7 held", {7'b0, irq}, 8'h01);
        rd(5'd8, v); chk("R7 sts bit1", {7'b0, v[1]}, 8'h00);
        wr(5'd7, 8'h04); wr(5'd8, 8'h02);
        chk("R7 lowered", {7'b0, irq}, 8'h00);

        // R4 status clear masks (error bit2 already sticky from sweep)
        pulse(4'h4, 4'h0);
        xfer_busy = 1'b1;
        rd(5'd8, v); chk("R4 set", v, 8'h0D);
        wr(5'd8, 8'hFF); rd(5'd8, v); chk("R4 w1c", v, 8'h05);
        xfer_busy = 1'b0;

        // R11 set wins over clear
        host_addr = 5'd8; host_wdata = 8'h08; host_wr = 1'b1; ev_set = 4'h4;
        @(posedge clk); #1 host_wr = 1'b0; ev_set = '0;
        rd(5'd8, v); chk("R11", v, 8'h0C);

        // R5 extended status
        wr(5'd9, 8'hFF); rd(5'd9, v); chk("R5 clr", v, 8'h40);
        bus_busy = 1'b1; rd(5'd9, v); chk("R5 busy", v, 8'h50);
        pulse(4'h9, 4'h0); rd(5'd9, v); chk("R5 log", v, 8'h59);
        wr(5'd9, 8'h01); rd(5'd9, v); chk("R5 partial", v, 8'h58);
        bus_busy = 1'b0; rd(5'd9, v); chk("R5 free", v, 8'h48);

        // R8 extended control
        pulse(4'h0, 4'hA); rd(5'd15, v); chk("R8 set", v, 8'hA0);
        wr(5'd15, 8'h20); rd(5'd15, v); chk("R8 w1c", v, 8'h80);
        wr(5'd15, 8'h4E); rd(5'd15, v); chk("R8 low", v, 8'h80);

        // R10 unimplemented offsets
        for (int a = 0; a < 32; a++) begin rd(a[4:0], v); snap[a] = v; end
        for (int a = 0; a < 32; a++)
            if (a < 4 || a == 6 || a >= 17) wr(a[4:0], 8'hFF);
        for (int a = 0; a < 32; a++) begin
            rd(a[4:0], v);
            chk((a < 4 || a == 6 || a >= 17) ? "R10 zero" : "R10 kept", v,
                (a < 4 || a == 6 || a >= 17) ? 8'h00 : snap[a]);
        end

        // R9 soft reset
        wr(5'd4, 8'h12); wr(5'd5, 8'h34); wr(5'd10, 8'h56); wr(5'd11, 8'h78);
        wr(5'd13, 8'h0F); pulse(4'h1, 4'h0);
        chk("R9 pre irq", {7'b0, irq}, 8'h01);
        wr(5'd15, 8'h01);
        wr(5'd13, 8'hFF);
        for (int a = 0; a < 32; a++) begin
            logic [7:0] e;
            e = rst_val(a);
            if (a == 4) e = 8'h12;
            if (a == 5) e = 8'h34;
            if (a == 10) e = 8'h56;
            if (a == 11) e = 8'h78;
            rd(a[4:0], v); chk("R9", v, e);
        end
        chk("R9 irq", {7'b0, irq}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule